// File: doc/BRIEF.md
# Table-Driven Composite Chroma Sample Generator

This block produces the 8-bit sample stream for a composite colour video output. It runs from a sample clock at eight times the colour subcarrier, which is about 28.636 MHz. A free-running phase counter steps through the eight sample positions of each subcarrier cycle. That phase, the requested colour code and a signal-kind select together address a level table. The table output is registered and then drives an external resistor DAC. Horizontal and vertical timing come from outside: the timing logic sets the signal kind for every sample, and the block turns each request into the matching waveform.

For picture samples, each colour traces one full subcarrier cycle over eight table words. The hue sets where the sine starts and the luma level sets the value it swings around. The sync tip, blanking, black and burst levels live in the same table. A line-flip input shifts the phase by half a cycle, which inverts the chroma and burst on alternate lines. A build-time variant with `PHASE_BITS = 4` uses sixteen samples per cycle at sixteen times the subcarrier.

Top module: `chroma_synth`

## Requirements
- R1: While `rst_n` is low, `sample` holds the blanking code 60 and the phase counter is held at 0.
- R2: The phase counter runs freely modulo 8, whatever the other inputs do. The first rising edge after reset is released presents the sample for phase 0, and each later edge presents the next phase.
- R3: Signal kind 0 (sync) gives the constant code 0 on every phase.
- R4: Signal kind 1 (blank) gives the constant code 60 and kind 3 (black) gives the constant code 70. The unused kinds 5, 6 and 7 behave as blank.
- R5: Signal kind 4 (picture) takes luma index L from colour bits [4:3] and hue h from colour bits [2:0], with a luma level of 90 + 40*L. Hue 0 gives that luma level as a constant, with no chroma.
- R6: For picture with h ≠ 0, the sample at phase p is luma + trunc(40*S(2*((p+h) mod 8))/64), where S(k) = round(64*sin(2πk/16)) and trunc rounds toward zero.
- R7: For every one of the 32 colour codes, the eight picture samples of one subcarrier cycle sum to eight times that colour's luma level.
- R8: Signal kind 2 (burst) gives 60 + trunc(20*S(2*((p+4) mod 8))/64), which is a sinusoid about the blanking level at the reference phase of 180 degrees.
- R9: With `line_flip` high, the burst and picture samples use phase p+4 in place of p. Each burst sample's deviation from 60 therefore changes sign relative to the same phase with `line_flip` low.
- R10: `sample` is registered: a change of `sig_type`, `color` or `line_flip` first shows on the output after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, eight times the subcarrier |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_type | input | 3 | Signal kind: 0 sync, 1 blank, 2 burst, 3 black, 4 picture |
| color | input | 5 | Colour code: bits [4:3] luma index, bits [2:0] hue |
| line_flip | input | 1 | Adds half a subcarrier cycle to the phase on alternate lines |
| sample | output | 8 | Registered code for the DAC |

## Verification
All 32 colour codes are swept through a whole subcarrier cycle. Comparing each sample exactly against the sine model separates hue-phase errors from amplitude errors, and the eight-sample sum separates a wrong luma level from a wrong chroma shape. Burst is run with the line flip both low and high, so that a missing or wrong half-cycle offset shows up as deviations that do not change sign. Changes of signal kind are sampled just before and just after a clock edge, and the phase count is checked across a kind change: together these expose a missing output register and a phase counter that restarts when the inputs change.

// File: rtl/chroma_pkg.sv
package chroma_pkg;

    typedef enum logic [2:0] {
        SIG_SYNC    = 3'd0,
        SIG_BLANK   = 3'd1,
        SIG_BURST   = 3'd2,
        SIG_BLACK   = 3'd3,
        SIG_PICTURE = 3'd4
    } sig_kind_e;

    // One sine cycle at sixteen points, scaled to +/-64 and rounded.
    function automatic int sine16(input logic [3:0] k);
        int v;
        unique case (k)
            4'd0:  v = 0;
            4'd1:  v = 24;
            4'd2:  v = 45;
            4'd3:  v = 59;
            4'd4:  v = 64;
            4'd5:  v = 59;
            4'd6:  v = 45;
            4'd7:  v = 24;
            4'd8:  v = 0;
            4'd9:  v = -24;
            4'd10: v = -45;
            4'd11: v = -59;
            4'd12: v = -64;
            4'd13: v = -59;
            4'd14: v = -45;
            default: v = -24;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/chroma_phase_gen.sv
module chroma_phase_gen #(
    parameter int PHASE_BITS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [PHASE_BITS-1:0] phase
);
    // Phase state register: PH0 -> PH1 -> ... -> PH(N-1) -> PH0, wrapping freely.
    logic [PHASE_BITS-1:0] phase_q;
    logic [PHASE_BITS-1:0] phase_d;

    always_comb begin
        phase_d = phase_q + PHASE_BITS'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R2: the phase advances by exactly one every clock out of reset
    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase_q == $past(phase_q) + PHASE_BITS'(1));

endmodule

// File: rtl/chroma_level_rom.sv
module chroma_level_rom
    import chroma_pkg::*;
#(
    parameter int PHASE_BITS = 3,
    parameter int COLOR_BITS = 5,
    parameter int TYPE_BITS  = 3,
    parameter int SYNC_LVL   = 0,
    parameter int BLANK_LVL  = 60,
    parameter int BLACK_LVL  = 70,
    parameter int LUMA_BASE  = 90,
    parameter int LUMA_STEP  = 40,
    parameter int CHROMA_AMP = 40,
    parameter int BURST_AMP  = 20
) (
    input  logic [TYPE_BITS-1:0]  sig_type,
    input  logic [COLOR_BITS-1:0] color,
    input  logic [PHASE_BITS-1:0] phase,
    input  logic                  flip,
    output logic [7:0]            level
);
    localparam int N         = 1 << PHASE_BITS;
    localparam int HALF      = N / 2;
    localparam int STEP      = 16 / N;
    localparam int HUE_BITS  = 3;
    localparam int HUE_STEP  = N / 8;
    localparam int LUMA_BITS = COLOR_BITS - HUE_BITS;

    logic [PHASE_BITS-1:0] ph_eff;
    logic [PHASE_BITS-1:0] ph_burst;
    logic [PHASE_BITS-1:0] ph_pic;
    logic [HUE_BITS-1:0]   hue;
    logic [LUMA_BITS-1:0]  luma_idx;
    int                    luma;
    int                    val;

    always_comb begin
        hue      = color[HUE_BITS-1:0];
        luma_idx = color[COLOR_BITS-1:HUE_BITS];
        luma     = LUMA_BASE + LUMA_STEP * int'(luma_idx);
        ph_eff   = phase + (flip ? PHASE_BITS'(HALF) : '0);
        ph_burst = ph_eff + PHASE_BITS'(HALF);
        ph_pic   = ph_eff + PHASE_BITS'(int'(hue) * HUE_STEP);
        unique case (sig_type)
            SIG_SYNC:  val = SYNC_LVL;
            SIG_BLACK: val = BLACK_LVL;
            SIG_BURST: val = BLANK_LVL +
                (BURST_AMP * sine16(4'(int'(ph_burst) * STEP))) / 64;
            SIG_PICTURE: begin
                if (hue == '0) val = luma;
                else val = luma +
                    (CHROMA_AMP * sine16(4'(int'(ph_pic) * STEP))) / 64;
            end
            default:   val = BLANK_LVL;
        endcase
        level = 8'(val);
    end

endmodule

// File: rtl/chroma_synth.sv
module chroma_synth
    import chroma_pkg::*;
#(
    parameter int PHASE_BITS = 3,
    parameter int COLOR_BITS = 5,
    parameter int TYPE_BITS  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TYPE_BITS-1:0]  sig_type,
    input  logic [COLOR_BITS-1:0] color,
    input  logic                  line_flip,
    output logic [7:0]            sample
);
    localparam int BLANK_LVL = 60;
    localparam int LUMA_BASE = 90;
    localparam int LUMA_STEP = 40;

    logic [PHASE_BITS-1:0] phase;
    logic [7:0]            level;
    logic [7:0]            sample_q;

    chroma_phase_gen #(.PHASE_BITS(PHASE_BITS)) i_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    chroma_level_rom #(
        .PHASE_BITS (PHASE_BITS),
        .COLOR_BITS (COLOR_BITS),
        .TYPE_BITS  (TYPE_BITS),
        .BLANK_LVL  (BLANK_LVL),
        .LUMA_BASE  (LUMA_BASE),
        .LUMA_STEP  (LUMA_STEP)
    ) i_rom (
        .sig_type (sig_type),
        .color    (color),
        .phase    (phase),
        .flip     (line_flip),
        .level    (level)
    );

    // Output register removes table settling glitches before the DAC.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sample_q <= 8'(BLANK_LVL);
        else        sample_q <= level;
    end

    assign sample = sample_q;

    a_r3_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sig_type == SIG_SYNC |=> sample_q == 8'd0);

    a_r4_blank_level: assert property (@(posedge clk) disable iff (!rst_n)
        sig_type == SIG_BLANK |=> sample_q == 8'(BLANK_LVL));

    a_r8_burst_range: assert property (@(posedge clk) disable iff (!rst_n)
        sig_type == SIG_BURST |=> (sample_q >= 8'd40 && sample_q <= 8'd80));

    a_r5_gray_flat: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_type == SIG_PICTURE && color[2:0] == 3'd0) |=>
        sample_q == $past(8'(LUMA_BASE + LUMA_STEP * int'(color[COLOR_BITS-1:3]))));

endmodule

// File: tb/test_chroma_synth.sv
module test_chroma_synth;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sig_type = 3'd1;
    logic [4:0] color = 5'd0;
    logic       line_flip = 1'b0;
    logic [7:0] sample;

    int total = 0;
    int bad = 0;
    int edges = 0;
    bit done = 1'b0;

    chroma_synth i_chroma_synth (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_type  (sig_type),
        .color     (color),
        .line_flip (line_flip),
        .sample    (sample)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    function automatic int s16(int k);
        return int'(64.0 * $sin(2.0 * 3.14159265358979 * real'(k) / 16.0));
    endfunction

    function automatic int luma_of(int c);
        return 90 + 40 * (c >> 3);
    endfunction

    function automatic int exp_sample(int t, int c, bit f, int p);
        int pe = (p + (f ? 4 : 0)) % 8;
        int h  = c & 7;
        case (t)
            0: return 0;
            2: return 60 + (20 * s16(((pe + 4) % 8) * 2)) / 64;
            3: return 70;
            4: begin
                if (h == 0) return luma_of(c);
                return luma_of(c) + (40 * s16(((pe + h) % 8) * 2)) / 64;
            end
            default: return 60;
        endcase
    endfunction

    function automatic int cur_phase();
        return (edges - 1) % 8;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(int t, int c, bit f);
        @(negedge clk);
        sig_type = 3'(t); color = 5'(c); line_flip = f;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Checks one full cycle against the model; returns the sample sum.
    task automatic check_cycle(string req, int t, int c, bit f, output int sum);
        sum = 0;
        apply(t, c, f);
        for (int i = 0; i < 8; i++) begin
            check(req, int'(sample), exp_sample(t, c, f, cur_phase()));
            sum += int'(sample);
            if (i < 7) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        sig_type = 3'd2; color = 5'd0; line_flip = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset level", int'(sample), 60);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2 first phase after reset", int'(sample), exp_sample(2, 0, 1'b0, 0));
        @(negedge clk);
        check("R2 second phase", int'(sample), exp_sample(2, 0, 1'b0, 1));
    endtask

    task automatic t_flat_levels();
        int s;
        check_cycle("R3 sync", 0, 9, 1'b0, s);
        check_cycle("R4 blank", 1, 9, 1'b0, s);
        check_cycle("R4 black", 3, 9, 1'b1, s);
        for (int t = 5; t < 8; t++) check_cycle("R4 unused kind", t, 13, 1'b0, s);
    endtask

    task automatic t_colors();
        int s;
        for (int c = 0; c < 32; c++) begin
            if ((c & 7) == 0) check_cycle("R5 gray", 4, c, 1'b0, s);
            else              check_cycle("R6 chroma", 4, c, 1'b0, s);
            check("R7 average", s, 8 * luma_of(c));
        end
        check_cycle("R9 picture flip", 4, 19, 1'b1, s);
        check("R7 average flipped", s, 8 * luma_of(19));
    endtask

    task automatic t_burst();
        int d0 [8];
        int d1 [8];
        int s;
        check_cycle("R8 burst", 2, 0, 1'b0, s);
        apply(2, 0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            d0[cur_phase()] = int'(sample) - 60;
            @(negedge clk);
        end
        check_cycle("R9 burst flip", 2, 0, 1'b1, s);
        apply(2, 0, 1'b1);
        for (int i = 0; i < 8; i++) begin
            d1[cur_phase()] = int'(sample) - 60;
            @(negedge clk);
        end
        for (int p = 0; p < 8; p++) check("R9 burst sign swap", d1[p], -d0[p]);
    endtask

    task automatic t_latency();
        int p0;
        apply(0, 0, 1'b0);
        p0 = cur_phase();
        sig_type = 3'd1;
        #1;
        check("R10 no change before edge", int'(sample), 0);
        @(posedge clk);
        @(negedge clk);
        check("R10 change after edge", int'(sample), 60);
        check("R2 phase continues across kind change", cur_phase(), (p0 + 1) % 8);
        sig_type = 3'd4; color = 5'd5;
        @(posedge clk);
        @(negedge clk);
        check("R2 phase free running", int'(sample), exp_sample(4, 5, 1'b0, (p0 + 2) % 8));
    endtask

    initial begin
        t_reset();
        t_flat_levels();
        t_colors();
        t_burst();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule